// File: doc/BRIEF.md
# Multi-Mode Interval Timer Channel

One down-counting timer channel of a programmable interval timer. A control strobe selects one of six operating modes and a binary or four-digit decimal (BCD) number format. A count strobe supplies the initial count. The channel decrements on every clock cycle in which the count-clock enable is high. It drives an output pin whose waveform depends on the mode, and it reacts to a gate input by pausing, restarting or triggering according to that mode. The live counter value and a null-count flag are visible on ports.

Byte-wide host access, counter latching and status read-back belong to a separate interface block. That block drives the control and count strobes of this channel and reads its counter, output and null-count flag.

Top module: `ivt_channel`

## Requirements
- R1: After a synchronous reset the output is low, the counter reads 0, the null-count flag is clear and the mode is 0.
- R2: A control strobe sets the null-count flag. It drives the output low when the mode code is 0 and high for every other code. Mode codes: 0 interrupt on terminal count, 1 retriggerable one-shot, 2 rate generator, 3 square wave, 4 software strobe, 5 hardware strobe.
- R3: A count strobe stores the initial count and sets the null-count flag. In modes 0, 2, 3 and 4 the value moves into the counter on the next count clock. In modes 1 and 5 it moves on a gate trigger. The null-count flag clears on that transfer. A written 0 means 65536 in binary, so the counter shows 0x0000 and then 0xFFFF. In BCD a written 0 loads 0x9999.
- R4: Mode 0 decrements only while the gate is high. Its output stays low until the count reaches 0, then goes high. The counter keeps wrapping after that, and in mode 0 a count strobe drives the output low.
- R5: In BCD each 4-bit digit counts 9 down to 0 and then borrows from the next digit, so 0x0010 steps to 0x0009 and 0x0000 wraps to 0x9999.
- R6: Mode 1: a rising gate edge loads the count and drives the output low. The output goes high when the count reaches 0. A new rising edge during the countdown reloads the count, and the gate level has no other effect.
- R7: Mode 2: the output is low for one count clock while the counter holds 1, then the initial count reloads and the output returns high. A low gate halts counting and forces the output high. A rising gate edge reloads the initial count.
- R8: Mode 2: a count strobe while the channel runs leaves the current period unchanged. The new value is used at the next reload.
- R9: Mode 3 loads the initial count rounded down to an even value (an odd count loses one). It steps by two and, with the counter at 2, reloads and toggles the output, so the counter never shows an odd value.
- R10: Modes 4 and 5 hold the output high except for one count clock when the counter first reaches 0. Mode 4 starts on the count strobe; mode 5 starts on a rising gate edge.
- R11: Mode codes 6 and 7 behave exactly as codes 2 and 3.
- R12: While the count-clock enable is low the counter does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count-clock enable, one count step per high cycle |
| gate | input | 1 | Gate input |
| ctrl_wr | input | 1 | Control strobe, takes ctrl_mode and ctrl_bcd |
| ctrl_mode | input | 3 | Mode code |
| ctrl_bcd | input | 1 | 1 selects BCD counting |
| cnt_wr | input | 1 | Count strobe, takes cnt_val |
| cnt_val | input | 16 | Initial count |
| out_q | output | 1 | Timer output |
| count_q | output | 16 | Live counter value |
| null_cnt | output | 1 | A written value has not yet entered the counter |

## Verification
Each mode is run with a small initial count, and the counter and output are compared on every count clock, including across reloads and wraps.

Binary and BCD runs of the same mode separate a plain subtraction from the per-digit borrow. A written 0 separates "maximum count" from "terminal count now".

Gate pulses are placed in the middle of a countdown. This shows which modes pause, which restart and which ignore the level. A count strobe placed inside a running rate-generator period shows whether the new value is deferred. Odd counts in mode 3 and aliased mode codes 6 and 7 cover the remaining encodings.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    typedef enum logic [2:0] {
        MD_TERM    = 3'd0,
        MD_ONESHOT = 3'd1,
        MD_RATE    = 3'd2,
        MD_SQUARE  = 3'd3,
        MD_SWSTB   = 3'd4,
        MD_HWSTB   = 3'd5
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  bcd;
    } chan_cfg_t;

    // codes 6 and 7 fold onto the rate and square-wave modes
    function automatic mode_e decode_mode(input logic [2:0] code);
        if (code > 3'd5) return mode_e'(code - 3'd4);
        return mode_e'(code);
    endfunction

endpackage

// File: rtl/ivt_step.sv
module ivt_step #(
    parameter  int DIGITS = 4,
    localparam int W      = 4 * DIGITS
) (
    input  logic [W-1:0] cur,
    input  logic         bcd,
    output logic [W-1:0] less1,
    output logic [W-1:0] less2
);
    logic [W-1:0] stg [3];
    assign stg[0] = cur;

    for (genvar s = 0; s < 2; s++) begin : g_stage
        logic [DIGITS-1:0] brw;
        logic [W-1:0]      bcd_res;
        assign brw[0] = 1'b1;
        for (genvar d = 0; d < DIGITS; d++) begin : g_dig
            logic [3:0] nib;
            assign nib = stg[s][4*d +: 4];
            assign bcd_res[4*d +: 4] = !brw[d] ? nib :
                                       ((nib == 4'd0) ? 4'd9 : nib - 4'd1);
            if (d < DIGITS - 1) begin : g_brw
                assign brw[d+1] = brw[d] && (nib == 4'd0);
            end
        end
        assign stg[s+1] = bcd ? bcd_res : (stg[s] - W'(1));
    end

    assign less1 = stg[1];
    assign less2 = stg[2];
endmodule

// File: rtl/ivt_gate_sense.sv
module ivt_gate_sense (
    input  logic clk,
    input  logic rst,
    input  logic gate,
    input  logic consume,
    output logic trig
);
    logic gate_q;
    logic held;

    assign trig = held | (gate & ~gate_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= 1'b0;
            held   <= 1'b0;
        end else begin
            gate_q <= gate;
            held   <= trig & ~consume;
        end
    end
endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
    import ivt_pkg::*;
#(
    parameter  int DIGITS = 4,
    localparam int W      = 4 * DIGITS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cnt_en,
    input  logic         gate,
    input  logic         ctrl_wr,
    input  logic [2:0]   ctrl_mode,
    input  logic         ctrl_bcd,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_val,
    output logic         out_q,
    output logic [W-1:0] count_q,
    output logic         null_cnt
);
    localparam logic [W-1:0] NINES = {DIGITS{4'h9}};
    localparam logic [W-1:0] ONE   = W'(1);
    localparam logic [W-1:0] TWO   = W'(2);

    chan_cfg_t    cfg;
    logic [W-1:0] init_r, cnt_r, dec1, dec2, init_eff, sq_load;
    logic         out_r, null_r, pend, armed, running, fired, trig, tick;

    assign tick     = cnt_en;
    assign init_eff = (cfg.bcd && init_r == '0) ? NINES : init_r;
    assign sq_load  = {init_eff[W-1:1], 1'b0};

    ivt_step #(.DIGITS(DIGITS)) u_step (
        .cur(cnt_r), .bcd(cfg.bcd), .less1(dec1), .less2(dec2)
    );

    ivt_gate_sense u_gate (
        .clk(clk), .rst(rst), .gate(gate),
        .consume(tick | ctrl_wr), .trig(trig)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '{mode: MD_TERM, bcd: 1'b0};
            init_r  <= '0;
            cnt_r   <= '0;
            out_r   <= 1'b0;
            null_r  <= 1'b0;
            pend    <= 1'b0;
            armed   <= 1'b0;
            running <= 1'b0;
            fired   <= 1'b0;
        end else if (ctrl_wr) begin
            cfg     <= '{mode: decode_mode(ctrl_mode), bcd: ctrl_bcd};
            out_r   <= (decode_mode(ctrl_mode) != MD_TERM);
            null_r  <= 1'b1;
            pend    <= 1'b0;
            armed   <= 1'b0;
            running <= 1'b0;
            fired   <= 1'b0;
        end else begin
            if (tick) begin
                case (cfg.mode)
                    MD_TERM, MD_SWSTB: begin
                        if (cfg.mode == MD_SWSTB) out_r <= 1'b1;
                        if (pend) begin
                            cnt_r   <= init_eff;
                            pend    <= 1'b0;
                            null_r  <= 1'b0;
                            fired   <= 1'b0;
                            running <= 1'b1;
                        end else if (running && gate) begin
                            cnt_r <= dec1;
                            if (dec1 == '0 && !fired) begin
                                fired <= 1'b1;
                                out_r <= (cfg.mode == MD_TERM);
                            end
                        end
                    end
                    MD_ONESHOT, MD_HWSTB: begin
                        if (cfg.mode == MD_HWSTB) out_r <= 1'b1;
                        if (trig && armed) begin
                            cnt_r   <= init_eff;
                            pend    <= 1'b0;
                            null_r  <= 1'b0;
                            fired   <= 1'b0;
                            running <= 1'b1;
                            out_r   <= (cfg.mode == MD_HWSTB);
                        end else if (running) begin
                            cnt_r <= dec1;
                            if (dec1 == '0 && !fired) begin
                                fired <= 1'b1;
                                out_r <= (cfg.mode == MD_ONESHOT);
                            end
                        end
                    end
                    default: begin
                        if (!gate) begin
                            out_r <= 1'b1;
                        end else if (armed && (trig || (pend && !running))) begin
                            cnt_r   <= (cfg.mode == MD_SQUARE) ? sq_load : init_eff;
                            pend    <= 1'b0;
                            null_r  <= 1'b0;
                            running <= 1'b1;
                            out_r   <= 1'b1;
                        end else if (running) begin
                            if (cfg.mode == MD_RATE) begin
                                if (cnt_r == ONE) begin
                                    cnt_r  <= init_eff;
                                    pend   <= 1'b0;
                                    null_r <= 1'b0;
                                    out_r  <= 1'b1;
                                end else begin
                                    cnt_r <= dec1;
                                    if (dec1 == ONE) out_r <= 1'b0;
                                end
                            end else begin
                                if (cnt_r == TWO) begin
                                    cnt_r  <= sq_load;
                                    pend   <= 1'b0;
                                    null_r <= 1'b0;
                                    out_r  <= ~out_r;
                                end else begin
                                    cnt_r <= dec2;
                                end
                            end
                        end
                    end
                endcase
            end
            if (cnt_wr) begin
                init_r <= cnt_val;
                null_r <= 1'b1;
                pend   <= 1'b1;
                armed  <= 1'b1;
                if (cfg.mode == MD_TERM) out_r <= 1'b0;
            end
        end
    end

    assign out_q    = out_r;
    assign count_q  = cnt_r;
    assign null_cnt = null_r;

    // R2: control strobe sets null-count and the mode's starting level
    a_r2_ctrl_level: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> null_cnt && (out_q == (decode_mode($past(ctrl_mode)) != MD_TERM)));

    // R3: a count strobe leaves the null-count flag set
    a_r3_null_on_write: assert property (@(posedge clk) disable iff (rst)
        (cnt_wr && !ctrl_wr) |=> null_cnt);

    // R7: rate-generator low pulse lasts one count clock
    a_r7_one_low: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == MD_RATE && !out_q && cnt_en && gate && !ctrl_wr) |=> out_q);

    // R9: square wave counter never odd once running
    a_r9_even_count: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == MD_SQUARE && running) |-> !count_q[0]);

    // R10: strobe pulse lasts one count clock
    a_r10_one_strobe: assert property (@(posedge clk) disable iff (rst)
        ((cfg.mode == MD_SWSTB || cfg.mode == MD_HWSTB) && !out_q && cnt_en && !ctrl_wr)
        |=> out_q);

    // R12: no count clock, no count change
    a_r12_hold: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> $stable(count_q));
endmodule

// File: tb/ivt_channel_test.sv
module ivt_channel_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_en = 1'b1;
    logic        gate = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [2:0]  ctrl_mode = 3'd0;
    logic        ctrl_bcd = 1'b0;
    logic        cnt_wr = 1'b0;
    logic [15:0] cnt_val = 16'd0;
    logic        out_q;
    logic [15:0] count_q;
    logic        null_cnt;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    ivt_channel uut (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .gate(gate),
        .ctrl_wr(ctrl_wr), .ctrl_mode(ctrl_mode), .ctrl_bcd(ctrl_bcd),
        .cnt_wr(cnt_wr), .cnt_val(cnt_val),
        .out_q(out_q), .count_q(count_q), .null_cnt(null_cnt)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic expect_co(input string tag, input int c, input bit o);
        check({tag, " count"}, int'(count_q), c);
        check({tag, " out"}, int'(out_q), int'(o));
    endtask

    task automatic adv(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ctrl_word(input logic [2:0] m, input logic b);
        ctrl_mode = m; ctrl_bcd = b; ctrl_wr = 1'b1;
        adv(1);
        ctrl_wr = 1'b0;
    endtask

    task automatic write_count(input logic [15:0] v);
        cnt_val = v; cnt_wr = 1'b1;
        adv(1);
        cnt_wr = 1'b0;
    endtask

    task automatic t_reset;
        expect_co("R1 reset", 0, 1'b0);
        check("R1 reset null", int'(null_cnt), 0);
    endtask

    task automatic t_mode0_basic;
        gate = 1'b1;
        ctrl_word(3'd0, 1'b0);
        check("R2 mode0 out low", int'(out_q), 0);
        check("R2 mode0 null", int'(null_cnt), 1);
        write_count(16'd5);
        check("R3 null before load", int'(null_cnt), 1);
        adv(1);
        expect_co("R3 load", 5, 1'b0);
        check("R3 null cleared", int'(null_cnt), 0);
        adv(4);
        expect_co("R4 count 1", 1, 1'b0);
        adv(1);
        expect_co("R4 terminal", 0, 1'b1);
        adv(1);
        expect_co("R4 wrap binary", 16'hFFFF, 1'b1);
    endtask

    task automatic t_mode0_gate_en;
        ctrl_word(3'd0, 1'b0);
        write_count(16'd10);
        adv(1);
        adv(2);
        expect_co("R4 before pause", 8, 1'b0);
        gate = 1'b0;
        adv(3);
        expect_co("R4 gate low pause", 8, 1'b0);
        gate = 1'b1;
        adv(1);
        expect_co("R4 resume", 7, 1'b0);
        cnt_en = 1'b0;
        adv(3);
        expect_co("R12 enable low hold", 7, 1'b0);
        cnt_en = 1'b1;
        adv(1);
        expect_co("R12 enable back", 6, 1'b0);
    endtask

    task automatic t_bcd;
        ctrl_word(3'd0, 1'b1);
        write_count(16'h0010);
        adv(1);
        expect_co("R5 bcd load", 16'h0010, 1'b0);
        adv(1);
        expect_co("R5 bcd borrow", 16'h0009, 1'b0);
        write_count(16'h0001);
        adv(1);
        expect_co("R5 bcd reload", 16'h0001, 1'b0);
        adv(1);
        expect_co("R5 bcd terminal", 16'h0000, 1'b1);
        adv(1);
        expect_co("R5 bcd wrap", 16'h9999, 1'b1);
        write_count(16'h0000);
        adv(1);
        expect_co("R3 bcd zero max", 16'h9999, 1'b0);
        ctrl_word(3'd0, 1'b0);
        write_count(16'h0000);
        adv(1);
        expect_co("R3 binary zero load", 0, 1'b0);
        adv(1);
        expect_co("R3 binary zero step", 16'hFFFF, 1'b0);
    endtask

    task automatic t_mode2;
        ctrl_word(3'd2, 1'b0);
        check("R2 mode2 out high", int'(out_q), 1);
        write_count(16'd4);
        adv(1);
        expect_co("R7 load", 4, 1'b1);
        adv(1);
        expect_co("R7 step", 3, 1'b1);
        write_count(16'd6);
        expect_co("R8 write mid period", 2, 1'b1);
        check("R8 null set", int'(null_cnt), 1);
        adv(1);
        expect_co("R7 low pulse", 1, 1'b0);
        adv(1);
        expect_co("R8 new value at reload", 6, 1'b1);
        check("R8 null cleared", int'(null_cnt), 0);
        adv(1);
        expect_co("R8 next step", 5, 1'b1);
    endtask

    task automatic t_mode2_gate;
        ctrl_word(3'd2, 1'b0);
        write_count(16'd5);
        adv(1);
        adv(2);
        expect_co("R7 pre gate", 3, 1'b1);
        gate = 1'b0;
        adv(2);
        expect_co("R7 gate low stop", 3, 1'b1);
        gate = 1'b1;
        adv(1);
        expect_co("R7 gate rise reload", 5, 1'b1);
        adv(1);
        expect_co("R7 after restart", 4, 1'b1);
    endtask

    task automatic t_mode6;
        ctrl_word(3'd6, 1'b0);
        write_count(16'd3);
        adv(1);
        expect_co("R11 code6 load", 3, 1'b1);
        adv(2);
        expect_co("R11 code6 low", 1, 1'b0);
        adv(1);
        expect_co("R11 code6 reload", 3, 1'b1);
    endtask

    task automatic t_mode3;
        ctrl_word(3'd3, 1'b0);
        write_count(16'd6);
        adv(1);
        expect_co("R9 load", 6, 1'b1);
        adv(2);
        expect_co("R9 by two", 2, 1'b1);
        adv(1);
        expect_co("R9 toggle low", 6, 1'b0);
        adv(3);
        expect_co("R9 toggle high", 6, 1'b1);
        ctrl_word(3'd7, 1'b0);
        write_count(16'd7);
        adv(1);
        expect_co("R11 code7 odd loses one", 6, 1'b1);
        adv(1);
        expect_co("R9 odd steps even", 4, 1'b1);
        ctrl_word(3'd3, 1'b1);
        write_count(16'h0012);
        adv(1);
        adv(2);
        expect_co("R5 bcd by two", 16'h0008, 1'b1);
    endtask

    task automatic t_mode1;
        gate = 1'b0;
        ctrl_word(3'd1, 1'b0);
        write_count(16'd3);
        adv(2);
        check("R3 oneshot waits null", int'(null_cnt), 1);
        check("R6 idle out", int'(out_q), 1);
        gate = 1'b1;
        adv(1);
        expect_co("R6 trigger", 3, 1'b0);
        check("R3 trigger clears null", int'(null_cnt), 0);
        adv(1);
        gate = 1'b0;
        adv(1);
        expect_co("R6 gate level ignored", 1, 1'b0);
        gate = 1'b1;
        adv(1);
        expect_co("R6 retrigger", 3, 1'b0);
        adv(3);
        expect_co("R6 terminal", 0, 1'b1);
        adv(1);
        expect_co("R6 stays high", 16'hFFFF, 1'b1);
    endtask

    task automatic t_strobes;
        ctrl_word(3'd4, 1'b0);
        write_count(16'd2);
        adv(1);
        expect_co("R10 sw load", 2, 1'b1);
        adv(1);
        expect_co("R10 sw step", 1, 1'b1);
        adv(1);
        expect_co("R10 sw strobe", 0, 1'b0);
        adv(1);
        expect_co("R10 sw back high", 16'hFFFF, 1'b1);
        gate = 1'b0;
        ctrl_word(3'd5, 1'b0);
        write_count(16'd2);
        adv(2);
        check("R10 hw waits", int'(null_cnt), 1);
        gate = 1'b1;
        adv(1);
        expect_co("R10 hw trigger", 2, 1'b1);
        adv(2);
        expect_co("R10 hw strobe", 0, 1'b0);
        adv(1);
        expect_co("R10 hw back high", 16'hFFFF, 1'b1);
    endtask

    initial begin
        adv(3);
        rst = 1'b0;
        adv(1);
        t_reset();
        t_mode0_basic();
        t_mode0_gate_en();
        t_bcd();
        t_mode2();
        t_mode2_gate();
        t_mode6();
        t_mode3();
        t_mode1();
        t_strobes();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule